// File: doc/BRIEF.md
# Bit-Serial Control Latch Loader

This block updates a remote control register over three wires: a serial data line, a shift clock and a latch strobe. The host offers a control word on a valid/ready request port. Once the word is taken, the block drives all three lines low for one step. It then clocks the word out starting from bit 0. Last, it raises the strobe once, so the remote register takes all of the new bits in a single update.

Every line state is held for a programmable number of system clocks, set by the step-divider input. This lets the same block drive slow remote parts from a fast core clock. The divider value is captured when a request is accepted. A transfer holds `busy` high for (3*WORD_W+2) steps and ends with a one-cycle `done` pulse.

Back-pressure rules: `req_ready` is high only while the block is idle. A word is taken on a clock edge where `req_valid` and `req_ready` are both high. While a transfer runs, `req_ready` stays low and any `req_valid` is left pending, not accepted. The requester may hold or withdraw its word during that time. No request is stored.

Top module: `serial_latch_loader`

## Requirements
- R1: Each transfer gives exactly WORD_W (default 20) rising edges on `ser_clk`, followed by exactly one `ser_strobe` pulse.
- R2: Bit k of the accepted word is on `ser_data` during the k-th `ser_clk` pulse (k counted from 0), so bit 0 is sent first.
- R3: While idle, all three lines are low. The first step after a word is accepted also keeps all three lines low.
- R4: For each bit, `ser_data` takes its value one step before `ser_clk` rises. It stays unchanged while `ser_clk` is high and through the low step that follows.
- R5: After the low step of the last bit, `ser_strobe` is high for one step, with `ser_data` and `ser_clk` both low.
- R6: `req_ready` equals the inverse of `busy`. A word is accepted only on an edge where `req_valid` and `req_ready` are both high. A `req_valid` raised during a transfer changes neither the word sent nor the number of transfers.
- R7: `done` is high for exactly one cycle, in the cycle where `ser_strobe` falls. `busy` is low in that same cycle.
- R8: Each step lasts max(`step_div`,1) clocks. A value of 0 acts as 1. `busy` stays high for (3*WORD_W+2) steps per transfer.
- R9: `step_div` is sampled when a word is accepted. Changing it during a transfer does not change that transfer's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request word offered |
| req_ready | output | 1 | Block can accept a word (idle) |
| req_word | input | WORD_W | Control word to send |
| step_div | input | DIV_W | Clocks per line step (0 acts as 1) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the strobe falls |
| ser_data | output | 1 | Serial data line to the remote latch |
| ser_clk | output | 1 | Shift clock to the remote latch |
| ser_strobe | output | 1 | Latch strobe to the remote latch |

## Verification
The assertions check these properties on every cycle:
- The lines stay quiet while idle.
- Data is held steady around each clock pulse.
- The strobe only appears with data and clock low.
- The clock pulse count is exactly WORD_W at each strobe.
- `done` is a single pulse on the falling strobe, and `busy` starts only from an accepted request.

Other behaviour needs the bench scenarios, because only they know the requested word and the divider value. These are: the exact word captured by a modelled remote shift register, bit-0-first ordering, step lengths for each divider value, freezing of the divider mid-transfer, and the lack of any effect from requests raised while busy.

// File: rtl/sll_pkg.sv
package sll_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LEAD   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_HIGH   = 3'd3,
    PH_LOW    = 3'd4,
    PH_STROBE = 3'd5
  } phase_t;
endpackage

// File: rtl/sll_step_timer.sv
module sll_step_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             restart,
  input  logic [DIV_W-1:0] step_div,
  output logic             step_end
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] hold_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;

  // a divider of zero behaves as one clock per step
  assign div_eff = (step_div == '0) ? ONE : step_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= ONE;
      cnt_q  <= '0;
    end else if (accept) begin
      hold_q <= div_eff;
      cnt_q  <= div_eff - ONE;
    end else if (restart) begin
      cnt_q <= hold_q - ONE;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign step_end = (cnt_q == '0);
endmodule

// File: rtl/sll_shifter.sv
module sll_shifter #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] word_in,
  output logic              bit_out,
  output logic              last_bit
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (accept) begin
      sr_q  <= word_in;
      idx_q <= '0;
    end else if (shift_en) begin
      sr_q  <= {1'b0, sr_q[WORD_W-1:1]};
      idx_q <= idx_q + CNT_ONE;
    end
  end

  assign bit_out  = sr_q[0];
  assign last_bit = (idx_q == LAST_IDX);
endmodule

// File: rtl/sll_sequencer.sv
module sll_sequencer
  import sll_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  logic   step_end,
  input  logic   last_bit,
  output phase_t phase,
  output logic   shift_en,
  output logic   restart,
  output logic   done
);
  phase_t st_q, st_d;
  logic   fin;

  always_comb begin
    st_d     = st_q;
    shift_en = 1'b0;
    fin      = 1'b0;
    unique case (st_q)
      PH_IDLE:   if (accept)   st_d = PH_LEAD;
      PH_LEAD:   if (step_end) st_d = PH_SETUP;
      PH_SETUP:  if (step_end) st_d = PH_HIGH;
      PH_HIGH:   if (step_end) st_d = PH_LOW;
      PH_LOW: begin
        if (step_end) begin
          shift_en = 1'b1;
          st_d     = last_bit ? PH_STROBE : PH_SETUP;
        end
      end
      PH_STROBE: begin
        if (step_end) begin
          fin  = 1'b1;
          st_d = PH_IDLE;
        end
      end
      default:   st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= fin;
    end
  end

  assign phase   = st_q;
  assign restart = step_end && (st_q != PH_IDLE);
endmodule

// File: rtl/sll_line_drive.sv
module sll_line_drive
  import sll_pkg::*;
(
  input  phase_t phase,
  input  logic   bit_in,
  output logic   ser_data,
  output logic   ser_clk,
  output logic   ser_strobe
);
  always_comb begin
    ser_data   = 1'b0;
    ser_clk    = 1'b0;
    ser_strobe = 1'b0;
    unique case (phase)
      PH_SETUP, PH_LOW: ser_data = bit_in;
      PH_HIGH: begin
        ser_data = bit_in;
        ser_clk  = 1'b1;
      end
      PH_STROBE: ser_strobe = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/serial_latch_loader.sv
module serial_latch_loader
  import sll_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_word,
  input  logic [DIV_W-1:0]  step_div,
  output logic              busy,
  output logic              done,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_strobe
);
  phase_t phase;
  logic   accept, step_end, restart, shift_en, bit_cur, last_bit;

  assign req_ready = (phase == PH_IDLE);
  assign busy      = ~req_ready;
  assign accept    = req_valid & req_ready;

  sll_step_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .accept(accept), .restart(restart),
    .step_div(step_div), .step_end(step_end)
  );

  sll_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .accept(accept), .shift_en(shift_en),
    .word_in(req_word), .bit_out(bit_cur), .last_bit(last_bit)
  );

  sll_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .step_end(step_end),
    .last_bit(last_bit), .phase(phase), .shift_en(shift_en),
    .restart(restart), .done(done)
  );

  sll_line_drive u_drive (
    .phase(phase), .bit_in(bit_cur),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_strobe(ser_strobe)
  );
endmodule

// File: rtl/sll_checker.sv
module sll_checker #(
  parameter int WORD_W = 20
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic ser_data,
  input logic ser_clk,
  input logic ser_strobe
);
  localparam int PC_W = $clog2(WORD_W + 2) + 1;

  logic [PC_W-1:0] pulse_cnt;
  logic            clk_prev;

  // counts shift clock pulses since the last accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt <= '0;
      clk_prev  <= 1'b0;
    end else begin
      clk_prev <= ser_clk;
      if (req_valid && req_ready) pulse_cnt <= '0;
      else if (ser_clk && !clk_prev) pulse_cnt <= pulse_cnt + PC_W'(1);
    end
  end

  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_strobe) |-> (pulse_cnt == PC_W'(WORD_W))); // R1

  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_data && !ser_clk && !ser_strobe)); // R3

  AST_DATA_HELD_AROUND_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk || $fell(ser_clk)) |-> $stable(ser_data)); // R4

  AST_STROBE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_strobe |-> (!ser_data && !ser_clk)); // R5

  AST_BUSY_FROM_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready)); // R6

  AST_DONE_ON_STROBE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($fell(ser_strobe) && !busy)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
endmodule

bind serial_latch_loader sll_checker #(.WORD_W(WORD_W)) u_sll_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .ser_data(ser_data), .ser_clk(ser_clk),
  .ser_strobe(ser_strobe)
);

// File: tb/tb_serial_latch_loader.sv
module tb_serial_latch_loader;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 20;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [W-1:0]  req_word = '0;
  logic [DW-1:0] step_div = '0;
  logic          busy, done, ser_data, ser_clk, ser_strobe;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_latch_loader #(.WORD_W(W), .DIV_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .step_div(step_div), .busy(busy), .done(done),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_strobe(ser_strobe)
  );

  // remote latch model: shift on clock rise, capture on strobe rise
  logic [W-1:0] model_sr = '0;
  logic [W-1:0] captured = '0;
  int model_pulses = 0;
  int strobe_cnt   = 0;
  int cap_pulses   = 0;
  int strobe_dirty = 0;

  always @(posedge ser_clk) begin
    model_sr = {ser_data, model_sr[W-1:1]};
    model_pulses++;
  end

  always @(posedge ser_strobe) begin
    captured   = model_sr;
    cap_pulses = model_pulses;
    strobe_cnt++;
    if (ser_data || ser_clk) strobe_dirty++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [W-1:0] w, input int dv, input bit poke, input bit chdiv);
    int hold = (dv == 0) ? 1 : dv;
    int busy_cyc = 0, clk_hi = 0, strb_hi = 0, first_clk = -1;
    int viol = 0, order_bad = 0, rdy_bad = 0, pidx = 0, strobes0;
    logic pclk = 1'b0, pdat = 1'b0;
    model_pulses = 0;
    strobe_dirty = 0;
    strobes0 = strobe_cnt;
    @(negedge clk);
    step_div = DW'(dv);
    req_word = w;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R6 accept", busy, 1);
    while (busy) begin
      if (poke && busy_cyc == 5) begin
        req_valid = 1'b1;
        req_word  = ~w;
      end
      if (chdiv && busy_cyc == 3) step_div = DW'(dv + 3);
      if (req_ready) rdy_bad++;
      if (ser_clk) begin
        clk_hi++;
        if (first_clk < 0) first_clk = busy_cyc;
        if (!pclk) begin
          if (pidx < W && ser_data != w[pidx]) order_bad++;
          pidx++;
        end
        if (ser_data != pdat) viol++;
      end else if (pclk && ser_data != pdat) viol++;
      if (ser_strobe) strb_hi++;
      pclk = ser_clk;
      pdat = ser_data;
      busy_cyc++;
      @(negedge clk);
    end
    check(done == 1'b1, "R7 done at strobe fall", done, 1);
    req_valid = 1'b0;
    check(captured == w, "R2 captured word", captured, w);
    check(order_bad == 0, "R2 bit order", order_bad, 0);
    check(cap_pulses == W, "R1 pulse count", cap_pulses, W);
    check(strobe_cnt - strobes0 == 1, "R1 one strobe", strobe_cnt - strobes0, 1);
    check(first_clk == 2 * hold, "R3 quiet lead step", first_clk, 2 * hold);
    check(viol == 0, "R4 data hold", viol, 0);
    check(strobe_dirty == 0 && strb_hi == hold, "R5 strobe step", strb_hi, hold);
    check(rdy_bad == 0, "R6 ready low while busy", rdy_bad, 0);
    check(busy_cyc == (3 * W + 2) * hold, "R8 busy length", busy_cyc, (3 * W + 2) * hold);
    check(clk_hi == W * hold, "R8 clock high time", clk_hi, W * hold);
    if (chdiv) check(busy_cyc == (3 * W + 2) * hold, "R9 divider frozen", busy_cyc, (3 * W + 2) * hold);
    @(negedge clk);
    check(done == 1'b0, "R7 single pulse", done, 0);
    check(busy == 1'b0 && !ser_clk && !ser_strobe, "R6 no extra transfer", busy, 0);
    if (poke) check(strobe_cnt - strobes0 == 1 && captured == w, "R6 busy request ignored", captured, w);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && req_ready && !done, "R6 reset handshake", busy, 0);
    check(!ser_data && !ser_clk && !ser_strobe, "R3 reset lines", {ser_data, ser_clk, ser_strobe}, 0);
    for (int dv = 0; dv <= 4; dv++) begin
      run_xfer('0, dv, 1'b0, 1'b0);
      run_xfer('1, dv, 1'b0, 1'b0);
      run_xfer(20'h5A5A5, dv, 1'b0, 1'b0);
      run_xfer(20'hC0F31, dv, 1'b0, 1'b0);
    end
    for (int b = 0; b < W; b++) run_xfer(W'(1) << b, 1, 1'b0, 1'b0);
    for (int b = 0; b < W; b++) run_xfer(~(W'(1) << b), 2, 1'b0, 1'b0);
    run_xfer(20'h3C3C3, 2, 1'b1, 1'b0);
    run_xfer(20'h81234, 3, 1'b0, 1'b1);
    run_xfer(20'h00001, 0, 1'b1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule